// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a W-bit data stream by a fixed number of enabled clock cycles, N = 2^A. It does not shift the data through a chain of flip-flops. Each sample is written once into a memory with one write port and one read port, and two address counters step through that memory together. After reset the read counter points at entry zero and the write counter points at the top entry. The two counters therefore stay a fixed distance apart. A synchronous read register turns that distance into an end-to-end delay that matches an N-stage register chain.

An enable input advances the whole line by one step. When enable is low, the counters, the memory and the output register all keep their values, so a stall does not change the delay counted in enabled cycles. A small controller has two states. `ST_FILL` is the state after reset, while the memory still holds stale contents. `ST_RUN` is entered once N enabled cycles have passed. Its transitions are `FILL_DONE`, taken on the N-th enabled cycle (ST_FILL to ST_RUN), `FILL_WAIT`, which stays in ST_FILL on any earlier cycle, and `RUN_HOLD`, which stays in ST_RUN until the next reset. The output-valid flag is high exactly in `ST_RUN`.

Top module: `ramdelay_line`

## Requirements
- R1: While reset (synchronous, active high) is applied, `dout` is all zeros and `dout_vld` is 0 on the following clock edge.
- R2: After the enabled edge numbered j (the first enabled edge after reset is numbered 0), for j >= N-1, `dout` equals the `din` sampled at enabled edge j-N+1. The output therefore trails the input by exactly N enabled cycles.
- R3: `dout_vld` stays 0 after the first N-1 enabled edges that follow reset and becomes 1 after the N-th enabled edge.
- R4: An edge where `en` is 0 changes neither `dout` nor `dout_vld`. The delay counted in enabled cycles is the same across any number of such stalls.
- R5: Both address counters are A bits wide, step by one on each enabled edge and wrap from 2^A-1 to 0. Data stays correct across many wraps.
- R6: Reset applied in mid-stream returns the block to ST_FILL, clears `dout_vld` and restarts the N-cycle fill.
- R7: The write address minus the read address, taken modulo 2^A, is always N-1. The same entry is never read and written on one edge.
- R8: Once in ST_RUN, `dout_vld` stays 1 until the next reset (transition RUN_HOLD).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the line by one step |
| din | input | W | Sample entering the line |
| dout | output | W | Sample leaving the line, N enabled cycles later |
| dout_vld | output | 1 | High once the output carries written data |

## Verification
Suppose one of the counters resets to the wrong value or steps at the wrong time. The gap between the counters then changes. From the first valid output onward, every sample comes out early, late or from the wrong lap, so the bench sees the fault N enabled cycles after reset. A controller that leaves ST_FILL too soon or too late shows a `dout_vld` edge that is off by the same number of cycles. An enable that leaks into the counters or into the output register changes `dout` on the stall cycle itself, or shifts every later sample by one position.

// File: rtl/ramdelay_pkg.sv
package ramdelay_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_t;

endpackage

// File: rtl/ramdelay_ptr.sv
module ramdelay_ptr #(
    parameter int          A       = 4,
    parameter logic [A-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [A-1:0] ptr
);

    localparam logic [A-1:0] ONE = A'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= RST_VAL;
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end

    // R5: one step per enabled edge, wrapping modulo 2^A
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> ptr == $past(ptr) + ONE);

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr));

endmodule

// File: rtl/ramdelay_mem.sv
module ramdelay_mem #(
    parameter int W = 8,
    parameter int A = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [A-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic [A-1:0] rd_addr,
    output logic [W-1:0] rd_data
);

    localparam int DEPTH = 1 << A;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end

    // R7: the two ports never touch the same entry on one edge
    p_no_collide_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |-> wr_addr != rd_addr);

endmodule

// File: rtl/ramdelay_fill_fsm.sv
module ramdelay_fill_fsm #(
    parameter int A = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic vld
);
    import ramdelay_pkg::*;

    localparam logic [A-1:0] LAST = A'((1 << A) - 1);
    localparam logic [A-1:0] ONE  = A'(1);

    fill_state_t  state_q, state_d;
    logic [A-1:0] fill_q, fill_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // next state: FILL_WAIT, FILL_DONE, RUN_HOLD
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_FILL: begin
                if (en) begin
                    if (fill_q == LAST) begin
                        state_d = ST_RUN;
                    end else begin
                        fill_d = fill_q + ONE;
                    end
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        vld = (state_q == ST_RUN);
    end

    // R8: RUN_HOLD keeps the flag up until reset
    p_vld_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        vld |=> vld);

    // R3: the flag only rises on an enabled edge
    p_vld_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(vld) |-> $past(en));

endmodule

// File: rtl/ramdelay_line.sv
module ramdelay_line #(
    parameter int W = 8,
    parameter int A = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_vld
);

    localparam int           N       = 1 << A;
    localparam logic [A-1:0] RD_INIT = '0;
    localparam logic [A-1:0] WR_INIT = A'(N - 1);
    localparam logic [A-1:0] GAP     = A'(N - 1);

    logic [A-1:0] rd_addr;
    logic [A-1:0] wr_addr;

    ramdelay_ptr #(.A(A), .RST_VAL(RD_INIT)) u_rd_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (en),
        .ptr  (rd_addr)
    );

    ramdelay_ptr #(.A(A), .RST_VAL(WR_INIT)) u_wr_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (en),
        .ptr  (wr_addr)
    );

    ramdelay_mem #(.W(W), .A(A)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_en   (en),
        .rd_addr (rd_addr),
        .rd_data (dout)
    );

    ramdelay_fill_fsm #(.A(A)) u_fsm (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .vld (dout_vld)
    );

    // R7: fixed distance between the two counters
    p_ptr_gap_r7: assert property (@(posedge clk) disable iff (rst)
        A'(wr_addr - rd_addr) == GAP);

    // R4: a stalled edge changes nothing at the outputs
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout) && $stable(dout_vld));

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dout == '0) && !dout_vld);

endmodule

// File: tb/ramdelay_line_test.sv
`timescale 1ns/1ps
module ramdelay_line_test;

    localparam int W = 8;
    localparam int A = 4;
    localparam int N = 1 << A;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_vld;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] hist [1024];
    int           cnt   = 0;
    logic [W-1:0] exp_d = '0;
    logic         exp_v = 1'b0;
    logic [W-1:0] lfsr  = 8'hA5;

    always #2 clk = ~clk;

    ramdelay_line #(.W(W), .A(A)) uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    task automatic check_v(input string tag);
        checks++;
        if (dout_vld !== exp_v) begin
            failures++;
            $display("FAIL %s dout_vld actual=%0b expected=%0b cnt=%0d", tag, dout_vld, exp_v, cnt);
        end
    endtask

    task automatic check_d(input string tag);
        checks++;
        if (dout !== exp_d) begin
            failures++;
            $display("FAIL %s dout actual=%0h expected=%0h cnt=%0d", tag, dout, exp_d, cnt);
        end
    endtask

    task automatic step(input logic e, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        en  = e;
        din = d;
        @(posedge clk);
        #1;
        if (e) begin
            hist[cnt] = d;
            cnt++;
            if (cnt >= N) begin
                exp_v = 1'b1;
                exp_d = hist[cnt - N];
            end
        end
        check_v(tag);
        if (exp_v) check_d(tag);
    endtask

    function automatic logic [W-1:0] next_rand();
        lfsr = {lfsr[W-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr;
    endfunction

    // R1 and R6: reset clears outputs and restarts the fill
    task automatic t_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        din = 8'hFF;
        @(posedge clk);
        @(posedge clk);
        #1;
        cnt   = 0;
        exp_v = 1'b0;
        exp_d = '0;
        check_v(tag);
        check_d(tag);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
    endtask

    // R3: valid low for N-1 enabled edges, high on the N-th
    task automatic t_fill();
        for (int i = 0; i < N; i++) begin
            step(1'b1, W'(i + 8'h30), "R3_fill");
        end
    endtask

    // R2 and R5: a counting pattern and a pseudo-random pattern over many wraps
    task automatic t_stream();
        for (int i = 0; i < 3 * N; i++) begin
            step(1'b1, W'(8'hC0 + i), "R2_count");
        end
        for (int i = 0; i < 8 * N; i++) begin
            step(1'b1, next_rand(), "R5_wrap");
        end
    endtask

    // R4 and R8: stalls of several lengths keep outputs and delay intact
    task automatic t_stall();
        for (int k = 1; k < 6; k++) begin
            for (int i = 0; i < k; i++) begin
                step(1'b0, 8'hEE, "R4_stall");
            end
            for (int i = 0; i < 3; i++) begin
                step(1'b1, next_rand(), "R8_run");
            end
        end
    endtask

    // R3 and R4: stalls during the fill do not count toward it
    task automatic t_fill_stall();
        for (int i = 0; i < N; i++) begin
            step(1'b0, 8'h11, "R4_fillstall");
            step(1'b1, next_rand(), "R3_fillstall");
        end
        for (int i = 0; i < 2 * N; i++) begin
            step(1'b1, next_rand(), "R2_after");
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset("R1_reset");
        t_fill();
        t_stream();
        t_stall();
        for (int i = 0; i < 5; i++) begin
            step(1'b1, next_rand(), "R2_mid");
        end
        t_reset("R6_midreset");
        t_fill_stall();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule